// File: doc/BRIEF.md
# Reset and Defaults Initialization Sequencer

This block merges three reset sources into one internal reset and then runs the start-up sequence that fills a register file with its power-up values. The three sources are two supply-good detectors and an external active-low reset pin. While any source is active, every register and counter of the block is held at zero, and so is the internal reset output. After the last source releases, a synchroniser adds a fixed latency. A timed hold then keeps the internal reset asserted for a fixed number of clock cycles.

When the hold ends, the internal reset is released. In the same cycle the block starts writing a computed table of default values into the register file, one address per clock. Each entry is flagged as belonging either to the immediate group or to the chain group. The chain group is the vertical-sync-updated group, and its shadowed values only take effect at the next vertical sync pulse. The first vertical sync after the load completes produces a one-cycle commit strobe. The busy flag tells the host serial-bus slave to refuse register access. It is raised throughout reset and stays up for a fixed window measured from reset release. A new reset from any source at any phase restarts the whole sequence.

The vertical sync input is assumed synchronous to the clock. At the nominal 5 MHz clock, the defaults give a 4 µs hold and a 60 µs busy window.

Top module: `init_sequencer`

## Requirements
- R1: While any of `sup_a_ok`, `sup_b_ok` or `ext_rst_n` is low, the outputs take their cleared values at once, without waiting for a clock edge: `rst_int_n`=0, `busy`=1, `wr_en`=0, `chain_commit`=0.
- R2: Count the clock edges since the last source went high, with the first rising edge after release counted as 1. `rst_int_n` is low up to edge SYNC_STAGES+HOLD_CYC−1 and goes high at edge SYNC_STAGES+HOLD_CYC (default 22).
- R3: Any source going low during the hold, the load, the wait for vertical sync, or after completion restarts the sequence from the cleared state. The timing of R2, R4, R7 and R8 is then measured again from the new release.
- R4: `wr_en` is high for exactly N_DEF consecutive cycles. It rises at the same edge as `rst_int_n`. `wr_addr` counts 0, 1, …, N_DEF−1, rising by one each cycle.
- R5: During a write, `wr_data` equals (37·`wr_addr` + 5) mod 2^DW.
- R6: During a write, `wr_chain` is 1 exactly when `wr_addr` ≥ N_DEF−N_CHAIN, and 0 otherwise.
- R7: `busy` is high from reset until edge SYNC_STAGES+BUSY_CYC after release (default 302). At that edge it goes low and stays low until the next reset.
- R8: `chain_commit` is high for one cycle, combinationally with `vsync`, in the first cycle after the load in which `vsync` is high. A `vsync` during the hold or the load is ignored. Only one commit occurs per sequence, even if `vsync` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (nominally 5 MHz) |
| sup_a_ok | input | 1 | First supply good detector, low forces reset |
| sup_b_ok | input | 1 | Second supply good detector, low forces reset |
| ext_rst_n | input | 1 | External reset pin, active low |
| vsync | input | 1 | Vertical sync pulse, synchronous to clk |
| rst_int_n | output | 1 | Internal reset for the rest of the chip, active low |
| busy | output | 1 | Host register access must be refused while high |
| wr_en | output | 1 | Default-table write strobe to the register file |
| wr_addr | output | AW | Register file address being written |
| wr_data | output | DW | Default value for `wr_addr` |
| wr_chain | output | 1 | Entry belongs to the vertical-sync-updated group |
| chain_commit | output | 1 | Apply shadowed chain-group defaults now |

## Verification
On every cycle, the bound checker enforces several ordering rules. Busy never drops before the internal reset releases. Writes happen only inside the busy window, with addresses stepping by one and staying in range. The internal reset rises together with the write of address 0. A commit always coincides with `vsync`, happens outside the load, and occurs once per sequence. The exact cycle counts of the hold, the load and the busy window cannot be shown by these properties. Nor can the table contents, the group boundary, the ignoring of early `vsync`, or restarts in every phase. Only the bench's reference model, compared against every output on every cycle across its reset scenarios, shows those.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_LOAD = 2'd1,
    ST_ARM  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  // Default value rule for one table address (truncated by the user).
  function automatic int unsigned def_value(input int unsigned addr);
    return addr * 37 + 5;
  endfunction

endpackage

// File: rtl/init_rst_sync.sv
module init_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/init_default_rom.sv
module init_default_rom #(
  parameter int N_DEF   = 16,
  parameter int N_CHAIN = 4,
  parameter int DW      = 8,
  parameter int AW      = 4
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic          chain
);
  import init_seq_pkg::*;

  logic [DW-1:0] rom      [N_DEF];
  logic          rom_chn  [N_DEF];

  for (genvar i = 0; i < N_DEF; i++) begin : g_entry
    assign rom[i]     = DW'(def_value(i));
    assign rom_chn[i] = (i >= N_DEF - N_CHAIN);
  end

  always_comb begin
    data  = '0;
    chain = 1'b0;
    if (int'(addr) < N_DEF) begin
      data  = rom[addr];
      chain = rom_chn[addr];
    end
  end

endmodule

// File: rtl/init_seq_ctrl.sv
module init_seq_ctrl #(
  parameter int HOLD_CYC = 20,
  parameter int BUSY_CYC = 300,
  parameter int N_DEF    = 16,
  parameter int AW       = 4,
  parameter int TW       = 9
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          go,
  input  logic          vsync,
  output logic          rst_int_n,
  output logic          busy,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          chain_commit
);
  import init_seq_pkg::*;

  localparam logic [TW-1:0] T_HOLD = TW'(HOLD_CYC);
  localparam logic [TW-1:0] T_LEND = TW'(HOLD_CYC + N_DEF);
  localparam logic [TW-1:0] T_BUSY = TW'(BUSY_CYC);

  seq_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;
  logic          rst_q, rst_d;

  // Next-state logic; every register clears on any source (R1, R3).
  always_comb begin
    tmr_en = go && (tmr_q != T_BUSY);
    tmr_d  = tmr_q;
    if (tmr_en) tmr_d = tmr_q + 1'b1;

    st_d = st_q;
    unique case (st_q)
      ST_HOLD: if (tmr_d >= T_HOLD) st_d = ST_LOAD;
      ST_LOAD: if (tmr_d >= T_LEND) st_d = ST_ARM;
      ST_ARM:  if (vsync)           st_d = ST_DONE;
      ST_DONE: st_d = ST_DONE;
      default: st_d = ST_HOLD;
    endcase

    rst_d = (tmr_d >= T_HOLD);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q  <= ST_HOLD;
      tmr_q <= '0;
      rst_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      rst_q <= rst_d;
    end
  end

  assign rst_int_n    = rst_q;
  assign busy         = (tmr_q != T_BUSY);
  assign wr_en        = (st_q == ST_LOAD);
  assign wr_addr      = AW'(tmr_q - T_HOLD);
  assign chain_commit = (st_q == ST_ARM) && vsync;

endmodule

// File: rtl/init_sequencer.sv
module init_sequencer #(
  parameter int DW          = 8,
  parameter int N_DEF       = 16,
  parameter int N_CHAIN     = 4,
  parameter int HOLD_CYC    = 20,
  parameter int BUSY_CYC    = 300,
  parameter int SYNC_STAGES = 2,
  localparam int AW = (N_DEF > 1) ? $clog2(N_DEF) : 1,
  localparam int TW = $clog2(BUSY_CYC + 1)
) (
  input  logic          clk,
  input  logic          sup_a_ok,
  input  logic          sup_b_ok,
  input  logic          ext_rst_n,
  input  logic          vsync,
  output logic          rst_int_n,
  output logic          busy,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_chain,
  output logic          chain_commit
);

  logic          arst_n;
  logic          src_sync_n;
  logic [DW-1:0] rom_data;
  logic          rom_chain;

  // Any low source asserts asynchronously; release passes the synchroniser.
  assign arst_n = sup_a_ok & sup_b_ok & ext_rst_n;

  init_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .sync_n (src_sync_n)
  );

  init_seq_ctrl #(
    .HOLD_CYC (HOLD_CYC),
    .BUSY_CYC (BUSY_CYC),
    .N_DEF    (N_DEF),
    .AW       (AW),
    .TW       (TW)
  ) u_ctrl (
    .clk          (clk),
    .arst_n       (arst_n),
    .go           (src_sync_n),
    .vsync        (vsync),
    .rst_int_n    (rst_int_n),
    .busy         (busy),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .chain_commit (chain_commit)
  );

  init_default_rom #(
    .N_DEF   (N_DEF),
    .N_CHAIN (N_CHAIN),
    .DW      (DW),
    .AW      (AW)
  ) u_rom (
    .addr  (wr_addr),
    .data  (rom_data),
    .chain (rom_chain)
  );

  assign wr_data  = wr_en ? rom_data : '0;
  assign wr_chain = wr_en & rom_chain;

endmodule

// File: rtl/init_sequencer_chk.sv
module init_sequencer_chk #(
  parameter int N_DEF = 16,
  parameter int AW    = 4
) (
  input logic          clk,
  input logic          arst_n,
  input logic          vsync,
  input logic          rst_int_n,
  input logic          busy,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          chain_commit
);

  logic seen_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)           seen_q <= 1'b0;
    else if (chain_commit) seen_q <= 1'b1;
  end

  // R7
  busy_order_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !busy |-> rst_int_n);

  // R4
  wr_window_chk: assert property (@(posedge clk) disable iff (!arst_n)
    wr_en |-> (busy && rst_int_n && int'(wr_addr) < N_DEF));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == AW'($past(wr_addr) + 1'b1)));

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_int_n) |-> (busy && wr_en && wr_addr == '0));

  // R8
  commit_once_chk: assert property (@(posedge clk) disable iff (!arst_n)
    chain_commit |-> !seen_q);

  // R8
  commit_when_chk: assert property (@(posedge clk) disable iff (!arst_n)
    chain_commit |-> (vsync && rst_int_n && !wr_en));

endmodule

bind init_sequencer init_sequencer_chk #(.N_DEF(N_DEF), .AW(AW)) u_chk (
  .clk          (clk),
  .arst_n       (arst_n),
  .vsync        (vsync),
  .rst_int_n    (rst_int_n),
  .busy         (busy),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .chain_commit (chain_commit)
);

// File: tb/tb_init_sequencer.sv
module tb_init_sequencer;
  localparam int H  = 20;
  localparam int B  = 300;
  localparam int N  = 16;
  localparam int C  = 4;
  localparam int DW = 8;
  localparam int SS = 2;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          sup_a_ok, sup_b_ok, ext_rst_n, vsync;
  logic          rst_int_n, busy, wr_en, wr_chain, chain_commit;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int since, committed, tests, fails, cyc;

  init_sequencer #(
    .DW(DW), .N_DEF(N), .N_CHAIN(C), .HOLD_CYC(H), .BUSY_CYC(B), .SYNC_STAGES(SS)
  ) dut (
    .clk(clk), .sup_a_ok(sup_a_ok), .sup_b_ok(sup_b_ok), .ext_rst_n(ext_rst_n),
    .vsync(vsync), .rst_int_n(rst_int_n), .busy(busy), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_chain(wr_chain),
    .chain_commit(chain_commit)
  );

  function automatic bit src_ok();
    return sup_a_ok && sup_b_ok && ext_rst_n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at since=%0d: actual=%0h expected=%0h", req, since, act, exp);
    end
  endtask

  // Reference model: expected outputs from edges since release.
  task automatic compare();
    bit e_wr;
    string p;
    p = (since == 0) ? "R1 " : "";
    e_wr = (since >= SS + H) && (since <= SS + H + N - 1);
    chk({p, "R2 rst_int_n"}, int'(rst_int_n), int'(since >= SS + H));
    chk({p, "R7 busy"}, int'(busy), int'(since < SS + B));
    chk({p, "R4 wr_en"}, int'(wr_en), int'(e_wr));
    chk({p, "R8 chain_commit"}, int'(chain_commit),
        int'(vsync && since >= SS + H + N && committed == 0));
    if (e_wr) begin
      int a;
      a = since - SS - H;
      chk("R4 wr_addr", int'(wr_addr), a);
      chk("R5 wr_data", int'(wr_data), (a * 37 + 5) % (1 << DW));
      chk("R6 wr_chain", int'(wr_chain), int'(a >= N - C));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (src_ok()) begin
      if (vsync && since >= SS + H + N && committed == 0) committed = 1;
      if (since < 100000) since++;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_src(input logic a, input logic b, input logic e);
    sup_a_ok = a; sup_b_ok = b; ext_rst_n = e;
    if (!src_ok()) begin since = 0; committed = 0; end
    #1 compare();
  endtask

  task automatic vpulse();
    vsync = 1'b1; tick(); vsync = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    sup_a_ok = 0; sup_b_ok = 0; ext_rst_n = 0; vsync = 0;
    since = 0; committed = 0; tests = 0; fails = 0; cyc = 0;
    @(negedge clk); compare();           // R1 reset state
    run(3);
    // Scenario 1: supplies up, pin released last (R2, R4, R5, R6, R7, R8)
    set_src(1, 0, 0); run(2);
    set_src(1, 1, 0); run(2);
    set_src(1, 1, 1);
    run(SS + H + 4);
    vpulse();                            // R8: vsync during load ignored
    run(N + 3);
    vpulse();                            // R8: commit
    run(5);
    vpulse();                            // R8: second vsync ignored
    run(B);
    // Scenario 2: R3 restart during load, then vsync held across load end
    set_src(1, 1, 0); run(3);
    set_src(1, 1, 1); run(SS + H + 6);
    set_src(1, 1, 0); run(2);            // R3
    set_src(1, 1, 1); run(SS + H + N - 3);
    vsync = 1'b1; run(6); vsync = 1'b0;  // R8: one commit only
    run(B);
    // Scenario 3: R3 restart in hold via sup_b, via sup_a after done
    set_src(1, 0, 1); run(2);
    set_src(1, 1, 1); run(10);
    set_src(0, 1, 1); run(1);            // R3 during hold
    set_src(1, 1, 1); run(B + 10);
    set_src(0, 1, 1); run(2);            // R3 after completion
    set_src(1, 1, 1); run(SS + H + N + 2);
    vpulse(); run(4);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule